// File: doc/BRIEF.md
# Memory-Reference Execution Sequencer

This block executes the memory-reference instructions of a 24-bit accumulator machine, one instruction at a time. A caller hands it an instruction word together with a one-cycle `start` pulse. The block owns the accumulator, the multiplier-quotient register, the program counter, a sticky overflow flag and two compare flags. It steps through one to four clock cycles against a synchronous word memory. A read strobe presented in one cycle returns the addressed word on `mem_rdata` in the following cycle. A write strobe stores `mem_wdata` at the edge that ends the cycle.

The word is split, most significant first, into a 6-bit opcode, an immediate-select bit, an indirect bit and a 16-bit address. The operand is one of three kinds. It can be an immediate formed from the indirect bit and the address field. It can be a word read directly from memory. It can be a word found through a single pointer word. `done` marks the final cycle of each instruction. All register updates take effect at the clock edge that ends that cycle.

Top module: `mref_seq`

## Requirements
- R1: After reset, `ac_q`, `mq_q` and `pc_q` are zero, `ovf_q`, `cc_zero` and `cc_neg` are 0, and `busy` and `done` are low.
- R2: The instruction word is instr[23:18] opcode, instr[17] immediate-select, instr[16] indirect, and instr[15:0] address. With instr[17]=1 the operand of an operand-using instruction is instr[16:0] sign-extended to 24 bits.
- R3: With instr[17]=0 and instr[16]=1, the low 16 bits of the pointer word at the address are the effective address. That word's own bits are never followed further.
- R4: Opcode 06 (octal) ANDs the operand into AC, 05 ORs it in, and 04 XORs it in.
- R5: Opcode 03 adds the operand to AC, 02 gives AC minus operand, and 01 gives operand minus AC, all modulo 2^24. A signed overflow sets `ovf_q`, which stays set until `ovf_clr` is high at a clock edge. A new overflow in that same cycle wins.
- R6: Opcode 10 loads AC from the operand and 11 loads MQ from it. Opcode 12 copies MQ to AC and 13 copies AC to MQ.
- R7: Opcode 16 sets `cc_zero` and `cc_neg` from AC minus operand and leaves AC unchanged.
- R8: Opcode 14 increments the addressed memory word and opcode 15 decrements it. The new value is also written to AC.
- R9: Opcode 20 stores AC, 23 stores MQ and 24 stores zero at the effective address.
- R10: Opcode 21 replaces only bits 15:0 of the memory word with AC[15:0]. Opcode 22 replaces only bits 23:16 with AC[23:16].
- R11: Opcode 34 loads PC in three ways. In immediate mode it takes the low 16 bits of the sign-extended immediate. In direct mode it takes the address field. In indirect mode it takes the low 16 bits of the pointer word.
- R12: Cycles from the start edge to the end of the `done` cycle are as follows. Operand instructions take 1 (immediate), 2 (direct) or 3 (indirect). Stores take 2 or 3. Opcodes 14 and 15 take 3 or 4. JMP takes 1, 1 or 2. Opcodes 12 and 13 take 1. `done` is high for exactly one cycle and only while `busy` is high.
- R13: `start` is ignored while `busy` is high. An opcode outside the listed set completes in 1 cycle and changes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing `instr` (accepted only when idle) |
| instr | input | 24 | Instruction word |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid the cycle after `mem_rd` |
| ac_q | output | 24 | Accumulator |
| mq_q | output | 24 | MQ register |
| pc_q | output | 16 | Program counter |
| ovf_q | output | 1 | Sticky signed-overflow flag |
| cc_zero | output | 1 | Last compare result was zero |
| cc_neg | output | 1 | Last compare result was negative |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final cycle of the current instruction |

## Verification
The bench first targets the negative immediate. A sequencer that dropped the indirect bit as the sign would produce a positive mask for AND and a wrong jump target. It then uses a pointer word whose upper bits carry a set indirect flag. A sequencer that chased a second level would land at the wrong address. Partial stores are run against memory words with a known background. Writing the whole word, or the wrong field, leaves mismatched bits behind. Cycle counts are measured for every addressing mode, so a wasted or missing memory phase shows up as a count error. The remaining targets are the overflow flag across a later non-arithmetic instruction and a clear, a `start` raised during a store, and an unassigned opcode. A flag that was not sticky, a restart mid-instruction, or a stray write would each change a visible register or memory word.

// File: rtl/mref_pkg.sv
package mref_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_SUR = 6'o01;
   localparam logic [OPC_W-1:0] OPC_SUB = 6'o02;
   localparam logic [OPC_W-1:0] OPC_ADD = 6'o03;
   localparam logic [OPC_W-1:0] OPC_XOR = 6'o04;
   localparam logic [OPC_W-1:0] OPC_IOR = 6'o05;
   localparam logic [OPC_W-1:0] OPC_AND = 6'o06;
   localparam logic [OPC_W-1:0] OPC_LAC = 6'o10;
   localparam logic [OPC_W-1:0] OPC_LMQ = 6'o11;
   localparam logic [OPC_W-1:0] OPC_MIA = 6'o12;
   localparam logic [OPC_W-1:0] OPC_MAI = 6'o13;
   localparam logic [OPC_W-1:0] OPC_INC = 6'o14;
   localparam logic [OPC_W-1:0] OPC_DEC = 6'o15;
   localparam logic [OPC_W-1:0] OPC_CMP = 6'o16;
   localparam logic [OPC_W-1:0] OPC_DAC = 6'o20;
   localparam logic [OPC_W-1:0] OPC_DAP = 6'o21;
   localparam logic [OPC_W-1:0] OPC_DIP = 6'o22;
   localparam logic [OPC_W-1:0] OPC_DMQ = 6'o23;
   localparam logic [OPC_W-1:0] OPC_DZM = 6'o24;
   localparam logic [OPC_W-1:0] OPC_JMP = 6'o34;

   typedef enum logic [3:0] {
      K_NONE, K_AND, K_IOR, K_XOR, K_ADD, K_SUB, K_SUR, K_LAC,
      K_LMQ, K_MIA, K_MAI, K_CMP, K_INC, K_DEC, K_JMP, K_STO
   } kind_e;

   typedef enum logic [2:0] {
      ST_AC, ST_MQ, ST_ZERO, ST_LOWF, ST_HIGHF
   } store_e;

   typedef struct packed {
      kind_e  kind;
      store_e st;
      logic   uses_arg;   // operand-consuming instruction
      logic   no_mem;     // never touches memory
      logic   is_jmp;
      logic   is_store;
      logic   is_incdec;
   } dec_t;

   typedef enum logic [2:0] {
      S_IDLE, S_FIRST, S_PTR, S_ARG, S_WBACK
   } phase_e;

endpackage

// File: rtl/mref_decode.sv
module mref_decode
   import mref_pkg::*;
#(
   parameter int OP_W = 6
) (
   input  logic [OP_W-1:0] op,
   output dec_t            dec
);

   if (OP_W != OPC_W) begin : g_bad_op_w
      $error("mref_decode: OP_W must equal the package opcode width");
   end

   always_comb begin
      dec = '{kind: K_NONE, st: ST_AC, uses_arg: 1'b0, no_mem: 1'b0,
              is_jmp: 1'b0, is_store: 1'b0, is_incdec: 1'b0};
      unique case (op)
         OPC_AND: dec.kind = K_AND;
         OPC_IOR: dec.kind = K_IOR;
         OPC_XOR: dec.kind = K_XOR;
         OPC_ADD: dec.kind = K_ADD;
         OPC_SUB: dec.kind = K_SUB;
         OPC_SUR: dec.kind = K_SUR;
         OPC_LAC: dec.kind = K_LAC;
         OPC_LMQ: dec.kind = K_LMQ;
         OPC_CMP: dec.kind = K_CMP;
         OPC_MIA: dec.kind = K_MIA;
         OPC_MAI: dec.kind = K_MAI;
         OPC_INC: dec.kind = K_INC;
         OPC_DEC: dec.kind = K_DEC;
         OPC_JMP: dec.kind = K_JMP;
         OPC_DAC: begin dec.kind = K_STO; dec.st = ST_AC;    end
         OPC_DMQ: begin dec.kind = K_STO; dec.st = ST_MQ;    end
         OPC_DZM: begin dec.kind = K_STO; dec.st = ST_ZERO;  end
         OPC_DAP: begin dec.kind = K_STO; dec.st = ST_LOWF;  end
         OPC_DIP: begin dec.kind = K_STO; dec.st = ST_HIGHF; end
         default: dec.kind = K_NONE;
      endcase
      dec.uses_arg  = dec.kind inside {K_AND, K_IOR, K_XOR, K_ADD, K_SUB,
                                       K_SUR, K_LAC, K_LMQ, K_CMP};
      dec.no_mem    = dec.kind inside {K_NONE, K_MIA, K_MAI};
      dec.is_jmp    = (dec.kind == K_JMP);
      dec.is_store  = (dec.kind == K_STO);
      dec.is_incdec = (dec.kind == K_INC) || (dec.kind == K_DEC);
   end

endmodule

// File: rtl/mref_alu.sv
module mref_alu
   import mref_pkg::*;
#(
   parameter int W = 24
) (
   input  kind_e        kind,
   input  logic [W-1:0] ac,
   input  logic [W-1:0] mq,
   input  logic [W-1:0] arg,
   output logic [W-1:0] ac_next,
   output logic         ac_we,
   output logic [W-1:0] mq_next,
   output logic         mq_we,
   output logic         ovf_set,
   output logic         cc_we,
   output logic         cc_z,
   output logic         cc_n
);

   localparam int MSB = W - 1;

   logic [W-1:0] sum, dif, rdif;

   assign sum  = ac + arg;
   assign dif  = ac - arg;
   assign rdif = arg - ac;

   always_comb begin
      ac_next = ac;
      ac_we   = 1'b0;
      mq_next = mq;
      mq_we   = 1'b0;
      ovf_set = 1'b0;
      cc_we   = 1'b0;
      unique case (kind)
         K_AND: begin ac_next = ac & arg; ac_we = 1'b1; end
         K_IOR: begin ac_next = ac | arg; ac_we = 1'b1; end
         K_XOR: begin ac_next = ac ^ arg; ac_we = 1'b1; end
         K_ADD: begin
            ac_next = sum; ac_we = 1'b1;
            ovf_set = (ac[MSB] == arg[MSB]) && (sum[MSB] != ac[MSB]);
         end
         K_SUB: begin
            ac_next = dif; ac_we = 1'b1;
            ovf_set = (ac[MSB] != arg[MSB]) && (dif[MSB] != ac[MSB]);
         end
         K_SUR: begin
            ac_next = rdif; ac_we = 1'b1;
            ovf_set = (ac[MSB] != arg[MSB]) && (rdif[MSB] != arg[MSB]);
         end
         K_LAC: begin ac_next = arg; ac_we = 1'b1; end
         K_LMQ: begin mq_next = arg; mq_we = 1'b1; end
         K_MIA: begin ac_next = mq;  ac_we = 1'b1; end
         K_MAI: begin mq_next = ac;  mq_we = 1'b1; end
         K_CMP: cc_we = 1'b1;
         default: ;
      endcase
   end

   assign cc_z = (dif == '0);
   assign cc_n = dif[MSB];

endmodule

// File: rtl/mref_merge.sv
module mref_merge
   import mref_pkg::*;
#(
   parameter int W    = 24,
   parameter int LO_W = 16
) (
   input  store_e       st,
   input  logic [W-1:0] ac,
   input  logic [W-1:0] mq,
   input  logic [W-1:0] old,
   output logic [W-1:0] wdata
);

   localparam int HI_W = W - LO_W;

   if (LO_W < 1 || LO_W >= W) begin : g_bad_lo
      $error("mref_merge: LO_W must lie strictly inside the word");
   end

   logic [W-1:0] lo_mask;
   assign lo_mask = {{HI_W{1'b0}}, {LO_W{1'b1}}};

   always_comb begin
      unique case (st)
         ST_AC:    wdata = ac;
         ST_MQ:    wdata = mq;
         ST_ZERO:  wdata = '0;
         ST_LOWF:  wdata = (old & ~lo_mask) | (ac & lo_mask);
         ST_HIGHF: wdata = (old & lo_mask) | (ac & ~lo_mask);
         default:  wdata = old;
      endcase
   end

endmodule

// File: rtl/mref_seq.sv
module mref_seq
   import mref_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int ADDR_W = 16,
   parameter int OP_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] instr,
   input  logic              ovf_clr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] ac_q,
   output logic [WORD_W-1:0] mq_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic              ovf_q,
   output logic              cc_zero,
   output logic              cc_neg,
   output logic              busy,
   output logic              done
);

   localparam int IMM_W  = ADDR_W + 1;
   localparam int SEL_B  = ADDR_W + 1;
   localparam int IND_B  = ADDR_W;
   localparam int OP_LSB = ADDR_W + 2;

   if (WORD_W != OP_W + 2 + ADDR_W) begin : g_bad_layout
      $error("mref_seq: word must be opcode + two mode bits + address");
   end

   phase_e            phase_q, phase_d;
   logic [WORD_W-1:0] ir_q;
   logic [ADDR_W-1:0] ea_q, ea_d;
   logic [WORD_W-1:0] tmp_q;
   dec_t              dec;
   logic              imm_sel, ind_sel;
   logic [WORD_W-1:0] imm_ext, arg;
   logic [WORD_W-1:0] alu_ac, alu_mq, st_data, bump;
   logic              alu_ac_we, alu_mq_we, alu_ovf, alu_cc_we, alu_z, alu_n;
   logic              first_last, exec_alu;

   assign imm_sel = ir_q[SEL_B];
   assign ind_sel = ir_q[IND_B];

   // sign extension of the immediate: the indirect bit is its sign
   if (WORD_W > IMM_W) begin : g_ext
      assign imm_ext = {{(WORD_W-IMM_W){ir_q[IND_B]}}, ir_q[IMM_W-1:0]};
   end else begin : g_noext
      assign imm_ext = ir_q[WORD_W-1:0];
   end

   mref_decode #(.OP_W(OP_W)) u_dec (
      .op  (ir_q[WORD_W-1:OP_LSB]),
      .dec (dec)
   );

   assign arg = (phase_q == S_FIRST) ? imm_ext : mem_rdata;

   mref_alu #(.W(WORD_W)) u_alu (
      .kind    (dec.kind),
      .ac      (ac_q),
      .mq      (mq_q),
      .arg     (arg),
      .ac_next (alu_ac),
      .ac_we   (alu_ac_we),
      .mq_next (alu_mq),
      .mq_we   (alu_mq_we),
      .ovf_set (alu_ovf),
      .cc_we   (alu_cc_we),
      .cc_z    (alu_z),
      .cc_n    (alu_n)
   );

   mref_merge #(.W(WORD_W), .LO_W(ADDR_W)) u_merge (
      .st    (dec.st),
      .ac    (ac_q),
      .mq    (mq_q),
      .old   (mem_rdata),
      .wdata (st_data)
   );

   assign bump = (dec.kind == K_INC) ? mem_rdata + WORD_W'(1)
                                     : mem_rdata - WORD_W'(1);

   // an instruction finishes in its first cycle when it needs no memory
   assign first_last = dec.no_mem
                     | (dec.uses_arg & imm_sel)
                     | (dec.is_jmp & (imm_sel | ~ind_sel));

   always_comb begin
      phase_d   = phase_q;
      ea_d      = ea_q;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = ea_q;
      mem_wdata = st_data;
      done      = 1'b0;
      exec_alu  = 1'b0;
      unique case (phase_q)
         S_IDLE: begin
            if (start) phase_d = S_FIRST;
         end
         S_FIRST: begin
            if (first_last) begin
               done     = 1'b1;
               exec_alu = ~dec.is_jmp;
               phase_d  = S_IDLE;
            end else begin
               mem_rd  = 1'b1;
               phase_d = ind_sel ? S_PTR : S_ARG;
            end
         end
         S_PTR: begin
            ea_d = mem_rdata[ADDR_W-1:0];
            if (dec.is_jmp) begin
               done    = 1'b1;
               phase_d = S_IDLE;
            end else begin
               mem_rd   = 1'b1;
               mem_addr = mem_rdata[ADDR_W-1:0];
               phase_d  = S_ARG;
            end
         end
         S_ARG: begin
            if (dec.is_incdec) begin
               phase_d = S_WBACK;
            end else begin
               done     = 1'b1;
               mem_wr   = dec.is_store;
               exec_alu = dec.uses_arg;
               phase_d  = S_IDLE;
            end
         end
         S_WBACK: begin
            done      = 1'b1;
            mem_wr    = 1'b1;
            mem_wdata = tmp_q;
            phase_d   = S_IDLE;
         end
         default: phase_d = S_IDLE;
      endcase
   end

   assign busy = (phase_q != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= S_IDLE;
         ir_q    <= '0;
         ea_q    <= '0;
         tmp_q   <= '0;
      end else begin
         phase_q <= phase_d;
         ea_q    <= ea_d;
         if (phase_q == S_IDLE && start) begin
            ir_q <= instr;
            ea_q <= instr[ADDR_W-1:0];
         end
         if (phase_q == S_ARG && dec.is_incdec) tmp_q <= bump;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q    <= '0;
         mq_q    <= '0;
         pc_q    <= '0;
         ovf_q   <= 1'b0;
         cc_zero <= 1'b0;
         cc_neg  <= 1'b0;
      end else begin
         if (exec_alu && alu_ac_we) ac_q <= alu_ac;
         if (exec_alu && alu_mq_we) mq_q <= alu_mq;
         if (exec_alu && alu_cc_we) begin
            cc_zero <= alu_z;
            cc_neg  <= alu_n;
         end
         if (phase_q == S_WBACK) ac_q <= tmp_q;
         if (done && dec.is_jmp) begin
            if (phase_q == S_PTR)  pc_q <= mem_rdata[ADDR_W-1:0];
            else if (imm_sel)      pc_q <= imm_ext[ADDR_W-1:0];
            else                   pc_q <= ir_q[ADDR_W-1:0];
         end
         if (exec_alu && alu_ovf)  ovf_q <= 1'b1;
         else if (ovf_clr)         ovf_q <= 1'b0;
      end
   end

endmodule

// File: rtl/mref_seq_chk.sv
module mref_seq_chk #(
   parameter int WORD_W = 24,
   parameter int ADDR_W = 16,
   parameter int MAX_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              ovf_clr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [WORD_W-1:0] ac_q,
   input logic [WORD_W-1:0] mq_q,
   input logic [ADDR_W-1:0] pc_q,
   input logic              ovf_q,
   input logic              busy,
   input logic              done
);

   localparam int CNT_W = $clog2(MAX_CYC + 2);

   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_cnt <= '0;
      else if (done)      busy_cnt <= '0;
      else if (busy)      busy_cnt <= busy_cnt + 1'b1;
   end

   // R12: no instruction stays busy longer than the longest sequence
   always_ff @(posedge clk) begin
      if (rst_n) assert_cycle_bound_R12: assert (busy_cnt < CNT_W'(MAX_CYC))
         else $error("instruction exceeded %0d cycles", MAX_CYC);
   end

   assert_done_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_start_taken_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

   assert_write_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> done);

   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q);

   assert_regs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> ($stable(ac_q) && $stable(mq_q) && $stable(pc_q)));

endmodule

bind mref_seq mref_seq_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MAX_CYC(4)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .ovf_clr (ovf_clr),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr),
   .ac_q    (ac_q),
   .mq_q    (mq_q),
   .pc_q    (pc_q),
   .ovf_q   (ovf_q),
   .busy    (busy),
   .done    (done)
);

// File: tb/test_mref_seq.sv
`timescale 1ns/1ps
module test_mref_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] instr = '0;
   logic        ovf_clr = 1'b0;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [23:0] mem_wdata;
   logic [23:0] mem_rdata = '0;
   logic [23:0] ac_q, mq_q;
   logic [15:0] pc_q;
   logic        ovf_q, cc_zero, cc_neg, busy, done;

   int checks = 0;
   int fails  = 0;

   logic [23:0] mem [256];

   always #4 clk = ~clk;

   mref_seq i_mref_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .ovf_clr(ovf_clr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .ac_q(ac_q), .mq_q(mq_q), .pc_q(pc_q), .ovf_q(ovf_q),
      .cc_zero(cc_zero), .cc_neg(cc_neg), .busy(busy), .done(done)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
   end

   function automatic logic [23:0] mk(input logic [5:0] op, input logic im,
                                      input logic ind, input logic [15:0] a);
      return {op, im, ind, a};
   endfunction

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [23:0] ins, output int cyc);
      logic seen;
      @(negedge clk);
      instr = ins; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      cyc = 0; seen = 1'b0;
      while (!seen && cyc < 12) begin
         @(negedge clk);
         cyc++;
         seen = done;
         if (!seen) @(posedge clk);
      end
      @(posedge clk); #1;
   endtask

   // sequential table: instruction, AC after, MQ after, cycle count
   localparam int NV = 11;
   localparam logic [23:0] V_INS [NV] = '{
      mk(6'o10, 1'b1, 1'b0, 16'h0005),   // R6 LAC imm
      mk(6'o03, 1'b0, 1'b0, 16'h0010),   // R5 ADD direct
      mk(6'o06, 1'b1, 1'b1, 16'hFF00),   // R2 R4 AND negative imm
      mk(6'o05, 1'b0, 1'b1, 16'h0011),   // R3 R4 IOR indirect
      mk(6'o04, 1'b0, 1'b0, 16'h0010),   // R4 XOR direct
      mk(6'o02, 1'b1, 1'b0, 16'h0001),   // R5 SUB imm
      mk(6'o01, 1'b1, 1'b0, 16'h0003),   // R5 SUR imm
      mk(6'o11, 1'b0, 1'b0, 16'h0012),   // R6 LMQ direct
      mk(6'o12, 1'b0, 1'b0, 16'h0000),   // R6 MIA
      mk(6'o10, 1'b1, 1'b0, 16'h0001),   // R6 LAC imm
      mk(6'o13, 1'b0, 1'b0, 16'h0000)    // R6 MAI
   };
   localparam logic [23:0] V_AC [NV] = '{
      24'h000005, 24'h12345B, 24'h123400, 24'h123456, 24'h000000, 24'hFFFFFF,
      24'h000004, 24'h000004, 24'h7FFFFF, 24'h000001, 24'h000001 };
   localparam logic [23:0] V_MQ [NV] = '{
      24'h0, 24'h0, 24'h0, 24'h0, 24'h0, 24'h0, 24'h0,
      24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 24'h000001 };
   localparam int V_CYC [NV] = '{1, 2, 1, 3, 2, 1, 1, 2, 1, 1, 1};

   initial begin : watchdog
      #1600000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      int cyc;
      for (int i = 0; i < 256; i++) mem[i] = 24'h0;
      mem[16] = 24'h123456;
      mem[17] = 24'hFF0010;   // pointer with upper bits (incl. its own indirect bit) set
      mem[18] = 24'h7FFFFF;
      mem[20] = 24'hABCDEF;
      mem[21] = 24'h00001F;
      mem[32] = 24'h555555;
      mem[33] = 24'h111111;
      mem[34] = 24'h222222;
      mem[35] = 24'h00000F;
      mem[36] = 24'h000025;
      mem[37] = 24'h000000;

      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 ac", ac_q, 24'h0);
      chk("R1 mq", mq_q, 24'h0);
      chk("R1 pc", {8'h0, pc_q}, 24'h0);
      chk("R1 flags", {19'h0, ovf_q, cc_zero, cc_neg, busy, done}, 24'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run(V_INS[i], cyc);
         chk($sformatf("R2/R4/R5/R6 vec%0d ac", i), ac_q, V_AC[i]);
         chk($sformatf("R6 vec%0d mq", i), mq_q, V_MQ[i]);
         chk($sformatf("R12 vec%0d cycles", i), 24'(cyc), 24'(V_CYC[i]));
      end
      chk("R5 no overflow in table", {23'h0, ovf_q}, 24'h0);

      // R5 overflow sticky and clear
      run(mk(6'o10, 1'b0, 1'b0, 16'h0012), cyc);
      run(mk(6'o03, 1'b1, 1'b0, 16'h0001), cyc);
      chk("R5 add wrap", ac_q, 24'h800000);
      chk("R5 ovf set", {23'h0, ovf_q}, 24'h1);
      run(mk(6'o10, 1'b1, 1'b0, 16'h0000), cyc);
      chk("R5 ovf sticky", {23'h0, ovf_q}, 24'h1);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      chk("R5 ovf cleared", {23'h0, ovf_q}, 24'h0);

      // R7 compare
      run(mk(6'o10, 1'b1, 1'b0, 16'h0005), cyc);
      run(mk(6'o16, 1'b1, 1'b0, 16'h0005), cyc);
      chk("R7 cmp equal flags", {22'h0, cc_zero, cc_neg}, 24'h2);
      chk("R7 cmp keeps ac", ac_q, 24'h000005);
      run(mk(6'o16, 1'b1, 1'b0, 16'h0007), cyc);
      chk("R7 cmp less flags", {22'h0, cc_zero, cc_neg}, 24'h1);
      chk("R7 cmp keeps ac", ac_q, 24'h000005);

      // R9 stores
      run(mk(6'o10, 1'b0, 1'b0, 16'h0014), cyc);
      run(mk(6'o20, 1'b0, 1'b0, 16'h001E), cyc);
      chk("R9 dac", mem[30], 24'hABCDEF);
      chk("R12 dac direct cycles", 24'(cyc), 24'd2);
      run(mk(6'o23, 1'b0, 1'b1, 16'h0015), cyc);
      chk("R9 dmq indirect", mem[31], 24'h000001);
      chk("R12 store indirect cycles", 24'(cyc), 24'd3);
      run(mk(6'o24, 1'b0, 1'b0, 16'h0020), cyc);
      chk("R9 dzm", mem[32], 24'h0);

      // R10 partial stores
      run(mk(6'o21, 1'b0, 1'b0, 16'h0021), cyc);
      chk("R10 low field", mem[33], 24'h11CDEF);
      run(mk(6'o22, 1'b0, 1'b0, 16'h0022), cyc);
      chk("R10 high field", mem[34], 24'hAB2222);

      // R8 increment / decrement
      run(mk(6'o14, 1'b0, 1'b0, 16'h0023), cyc);
      chk("R8 inc mem", mem[35], 24'h000010);
      chk("R8 inc ac", ac_q, 24'h000010);
      chk("R12 inc direct cycles", 24'(cyc), 24'd3);
      run(mk(6'o15, 1'b0, 1'b1, 16'h0024), cyc);
      chk("R8 dec mem", mem[37], 24'hFFFFFF);
      chk("R8 dec ac", ac_q, 24'hFFFFFF);
      chk("R12 dec indirect cycles", 24'(cyc), 24'd4);

      // R11 jumps
      run(mk(6'o34, 1'b1, 1'b1, 16'h1234), cyc);
      chk("R11 jmp imm", {8'h0, pc_q}, 24'h001234);
      chk("R12 jmp imm cycles", 24'(cyc), 24'd1);
      run(mk(6'o34, 1'b0, 1'b0, 16'h0042), cyc);
      chk("R11 jmp direct", {8'h0, pc_q}, 24'h000042);
      chk("R12 jmp direct cycles", 24'(cyc), 24'd1);
      run(mk(6'o34, 1'b0, 1'b1, 16'h0011), cyc);
      chk("R3 R11 jmp indirect one level", {8'h0, pc_q}, 24'h000010);
      chk("R12 jmp indirect cycles", 24'(cyc), 24'd2);

      // R13 start ignored while busy
      @(negedge clk);
      instr = mk(6'o20, 1'b0, 1'b0, 16'h0028); start = 1'b1;
      @(posedge clk); #1 instr = mk(6'o10, 1'b1, 1'b0, 16'h0007);
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk("R12 store done in second cycle", {23'h0, done}, 24'h1);
      @(posedge clk); #1;
      chk("R13 busy start ignored ac", ac_q, 24'hFFFFFF);
      chk("R13 busy start ignored mem", mem[40], 24'hFFFFFF);
      chk("R13 idle after", {23'h0, busy}, 24'h0);

      // R13 unassigned opcode
      run(mk(6'o40, 1'b0, 1'b0, 16'h0010), cyc);
      chk("R13 undef cycles", 24'(cyc), 24'd1);
      chk("R13 undef ac", ac_q, 24'hFFFFFF);
      chk("R13 undef mq", mq_q, 24'h000001);
      chk("R13 undef pc", {8'h0, pc_q}, 24'h000010);
      chk("R13 undef mem", mem[16], 24'h123456);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule